// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

A purely combinational 32-bit shifter for the integer execute stage of a RISC-style pipeline. It receives the six-bit function code of a register-format instruction, both source operands, the five-bit immediate shift-amount field and one selector bit. From these it produces logical left, logical right, arithmetic right or rotate-right results. Each operation comes in an immediate-amount form and a register-variable form.

The two right-shift codes, immediate and variable, each cover two operations. The selector bit chooses between them: a clear selector gives a zero-filling shift and a set selector gives a rotate. The variable forms read their amount from the low five bits of the rs operand and ignore every other rs bit. Any function code outside the six shift codes raises an illegal-operation flag and forces the result to zero, so a neighbouring unit can claim those codes.

The datapath is one right-moving barrel of five stages, which move the word by 1, 2, 4, 8 and 16 positions. A left shift is done by reversing the bit order of the word before the barrel and again after it. The fill at each stage depends on the operation: zeros, copies of the sign bit, or the bits that wrap around.

Top module: `shf_unit`

## Requirements
- R1: Function code 0x00 returns rt shifted left by the immediate amount, with zeros entering at bit 0.
- R2: Function code 0x02 with the selector at 0 returns rt shifted right logically by the immediate amount, with zeros entering at bit 31.
- R3: Function code 0x02 with the selector at 1 returns rt rotated right by the immediate amount n, equal to (rt >> n) | (rt << (32 - n)) for n from 1 to 31.
- R4: Function code 0x03 returns rt shifted right by the immediate amount, filling with copies of rt bit 31.
- R5: Function codes 0x04, 0x06 and 0x07 are the variable forms of R1, R2/R3 and R4. They take their amount from rs bits 4..0 and ignore both the immediate field and rs bits 31..5.
- R6: An amount of zero returns rt unchanged, for every shift and rotate code.
- R7: Every function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 sets illegal_o to 1 and drives result_o to zero. The six shift codes keep illegal_o at 0.
- R8: The selector bit has no effect on function codes 0x00, 0x03, 0x04 and 0x07.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_i | input | 6 | Function code of the register-format instruction |
| rot_sel_i | input | 1 | 1 selects rotate on codes 0x02 and 0x06 |
| shamt_i | input | 5 | Immediate shift amount |
| rs_i | input | 32 | rs operand; bits 4..0 give the variable amount |
| rt_i | input | 32 | rt operand, the value shifted |
| result_o | output | 32 | Shift or rotate result; zero when illegal |
| illegal_o | output | 1 | Function code is not a shift code |

## Verification
The block has no registers, so every result is due in the same cycle its inputs change. The bench drives a new set of inputs on a rising edge of its pacing clock and samples result_o and illegal_o on the following falling edge. This gives half a period for the decode and five-stage barrel to settle. A fixed vector table covers the fill patterns and boundary amounts of each code. A sweep then runs all 32 amounts through every legal code and compares the outputs with an independent operator-level model.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNC_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNC_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FUNC_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FUNC_W-1:0] FN_SRAV = 6'h07;

  typedef enum logic [1:0] {
    SK_LEFT = 2'd0,
    SK_RLOG = 2'd1,
    SK_RARI = 2'd2,
    SK_ROTR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  input  logic              rot_sel_i,
  output shift_kind_e       kind_o,
  output logic              var_amt_o,
  output logic              illegal_o
);
  always_comb begin
    kind_o    = SK_LEFT;
    var_amt_o = 1'b0;
    illegal_o = 1'b0;
    unique case (func_i)
      FN_SLL:  kind_o = SK_LEFT;
      FN_SRL:  kind_o = rot_sel_i ? SK_ROTR : SK_RLOG;
      FN_SRA:  kind_o = SK_RARI;
      FN_SLLV: begin kind_o = SK_LEFT; var_amt_o = 1'b1; end
      FN_SRLV: begin kind_o = rot_sel_i ? SK_ROTR : SK_RLOG; var_amt_o = 1'b1; end
      FN_SRAV: begin kind_o = SK_RARI; var_amt_o = 1'b1; end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] dout_o
);
  logic              is_left;
  logic              sign_bit;
  logic [DATA_W-1:0] din_rev;
  logic [DATA_W-1:0] stg_in;
  logic [DATA_W-1:0] stg_rev;
  logic [AMT_W:0][DATA_W-1:0] stg;

  assign is_left  = (kind_i == SK_LEFT);
  assign sign_bit = (kind_i == SK_RARI) & din_i[DATA_W-1];

  // left shift = reverse, shift right with zero fill, reverse
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign din_rev[b] = din_i[DATA_W-1-b];
    assign stg_rev[b] = stg[AMT_W][DATA_W-1-b];
  end

  assign stg_in = is_left ? din_rev : din_i;
  assign stg[0] = stg_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [S-1:0] fill;
    assign fill = (kind_i == SK_ROTR) ? stg[k][S-1:0] : {S{sign_bit}};
    assign stg[k+1] = amt_i[k] ? {fill, stg[k][DATA_W-1:S]} : stg[k];
  end

  assign dout_o = is_left ? stg_rev : stg[AMT_W];

  always_comb begin
    if (kind_i == SK_ROTR)
      assert_rot_keeps_bits_R3: assert ($countones(dout_o) == $countones(din_i))
        else $error("rotate changed the number of set bits");
    if (kind_i == SK_LEFT && amt_i != '0)
      assert_left_zero_lsb_R1: assert (dout_o[0] == 1'b0)
        else $error("left shift did not fill bit 0 with zero");
    if (kind_i == SK_RLOG && amt_i != '0)
      assert_rlog_zero_msb_R2: assert (dout_o[DATA_W-1] == 1'b0)
        else $error("logical right shift did not clear the top bit");
    if (kind_i == SK_RARI)
      assert_rari_sign_R4: assert (dout_o[DATA_W-1] == din_i[DATA_W-1])
        else $error("arithmetic right shift lost the sign");
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [FUNC_W-1:0] func_i,
  input  logic              rot_sel_i,
  input  logic [AMT_W-1:0]  shamt_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  shift_kind_e       kind;
  logic              var_amt;
  logic              dec_illegal;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] shifted;
  logic              unused_rs_hi;

  assign unused_rs_hi = ^rs_i[DATA_W-1:AMT_W];

  shf_decode u_dec (
    .func_i    (func_i),
    .rot_sel_i (rot_sel_i),
    .kind_o    (kind),
    .var_amt_o (var_amt),
    .illegal_o (dec_illegal)
  );

  // variable forms: low bits of rs only
  assign amt = var_amt ? rs_i[AMT_W-1:0] : shamt_i;

  shf_barrel #(.DATA_W(DATA_W)) u_bar (
    .din_i  (rt_i),
    .amt_i  (amt),
    .kind_i (kind),
    .dout_o (shifted)
  );

  assign result_o  = dec_illegal ? '0 : shifted;
  assign illegal_o = dec_illegal;

  always_comb begin
    if (illegal_o)
      assert_illegal_zero_R7: assert (result_o == '0)
        else $error("illegal code produced a nonzero result");
    if (!illegal_o && amt == '0)
      assert_zero_amt_pass_R6: assert (result_o == rt_i)
        else $error("zero amount altered rt");
  end
endmodule

// File: tb/tb_shf_unit.sv
module tb_shf_unit;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic [5:0]  func;
  logic        sel;
  logic [4:0]  sh;
  logic [W-1:0] rs, rt, res;
  logic        ill;
  int          checks = 0, errors = 0, cyc = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  shf_unit dut (
    .func_i(func), .rot_sel_i(sel), .shamt_i(sh),
    .rs_i(rs), .rt_i(rt), .result_o(res), .illegal_o(ill)
  );

  typedef struct packed {
    logic [5:0]  func;
    logic        sel;
    logic [4:0]  sh;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [31:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{6'h00,1'b0,5'd4 ,32'h0,        32'h000000F1,32'h00000F10,1'b0,4'd1}, // R1
    '{6'h00,1'b0,5'd31,32'h0,        32'h00000003,32'h80000000,1'b0,4'd1}, // R1
    '{6'h02,1'b0,5'd8 ,32'h0,        32'h81234567,32'h00812345,1'b0,4'd2}, // R2
    '{6'h02,1'b1,5'd8 ,32'h0,        32'h81234567,32'h67812345,1'b0,4'd3}, // R3
    '{6'h02,1'b1,5'd1 ,32'h0,        32'h00000001,32'h80000000,1'b0,4'd3}, // R3
    '{6'h03,1'b0,5'd4 ,32'h0,        32'h80000000,32'hF8000000,1'b0,4'd4}, // R4
    '{6'h03,1'b0,5'd31,32'h0,        32'h7FFFFFFF,32'h00000000,1'b0,4'd4}, // R4
    '{6'h03,1'b0,5'd31,32'h0,        32'h80000000,32'hFFFFFFFF,1'b0,4'd4}, // R4
    '{6'h04,1'b0,5'd31,32'hFFFFFFE3, 32'h00000001,32'h00000008,1'b0,4'd5}, // R5
    '{6'h06,1'b0,5'd0 ,32'h00000124, 32'hF0000000,32'h0F000000,1'b0,4'd5}, // R5
    '{6'h06,1'b1,5'd0 ,32'hABCD0010, 32'h12345678,32'h56781234,1'b0,4'd5}, // R5
    '{6'h07,1'b0,5'd0 ,32'h00000028, 32'h800000FF,32'hFF800000,1'b0,4'd5}, // R5
    '{6'h02,1'b1,5'd0 ,32'h0,        32'hDEADBEEF,32'hDEADBEEF,1'b0,4'd6}, // R6
    '{6'h06,1'b1,5'd9 ,32'h00000020, 32'hCAFEF00D,32'hCAFEF00D,1'b0,4'd6}, // R6
    '{6'h00,1'b1,5'd4 ,32'h0,        32'h00000001,32'h00000010,1'b0,4'd8}, // R8
    '{6'h03,1'b1,5'd4 ,32'h0,        32'h80000000,32'hF8000000,1'b0,4'd8}, // R8
    '{6'h01,1'b0,5'd4 ,32'h0,        32'h0000FFFF,32'h00000000,1'b1,4'd7}, // R7
    '{6'h05,1'b0,5'd4 ,32'h4,        32'h0000FFFF,32'h00000000,1'b1,4'd7}, // R7
    '{6'h2A,1'b0,5'd4 ,32'h4,        32'hFFFFFFFF,32'h00000000,1'b1,4'd7}, // R7
    '{6'h3F,1'b1,5'd0 ,32'h0,        32'h12345678,32'h00000000,1'b1,4'd7}  // R7
  };

  function automatic logic [W-1:0] ref_res(input logic [5:0] f, input logic s,
                                           input logic [4:0] n_imm, input logic [W-1:0] a,
                                           input logic [W-1:0] x);
    logic [4:0] n;
    n = f[2] ? a[4:0] : n_imm;
    case (f)
      6'h00, 6'h04: return x << n;
      6'h02, 6'h06: return s ? ((n == 0) ? x : ((x >> n) | (x << (32 - n)))) : x >> n;
      6'h03, 6'h07: return $unsigned($signed(x) >>> n);
      default:      return '0;
    endcase
  endfunction

  task automatic apply(input logic [5:0] f, input logic s, input logic [4:0] n,
                       input logic [W-1:0] a, input logic [W-1:0] x);
    @(posedge clk);
    func = f; sel = s; sh = n; rs = a; rt = x;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] er, input logic ei);
    checks++;
    if (res !== er || ill !== ei) begin
      errors++;
      $display("FAIL %s func=%h: result=%h illegal=%b expected result=%h illegal=%b",
               req, func, res, ill, er, ei);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    func = 6'h00; sel = 0; sh = 0; rs = '0; rt = '0;
    // idle state: zero inputs give zero result, legal code (R6, R7)
    @(negedge clk);
    check("R6", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].func, VECS[i].sel, VECS[i].sh, VECS[i].rs, VECS[i].rt);
      check($sformatf("R%0d", VECS[i].req), VECS[i].exp, VECS[i].ill);
    end

    // sweep every amount across the legal codes (R1 R2 R3 R4 R5)
    for (int c = 0; c < 8; c++) begin
      logic [5:0] f;
      f = 6'(c);
      if (c == 1 || c == 5) continue;
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < 32; n++) begin
          logic [W-1:0] x, a;
          x = 32'h9E37_79B9 ^ (32'h0101_0101 * n);
          a = {27'h5A5A5A5 ^ 27'(n), 5'(n)};
          apply(f, s[0], f[2] ? 5'(31 - n) : 5'(n), a, x);
          check(f[2] ? "R5" : (f == 6'h00 ? "R1" : (f == 6'h03 ? "R4" : (s == 1 ? "R3" : "R2"))),
                ref_res(f, s[0], f[2] ? 5'(31 - n) : 5'(n), a, x), 1'b0);
        end
      end
    end

    // every non-shift code is flagged (R7)
    for (int c = 8; c < 64; c++) begin
      apply(6'(c), 1'b1, 5'd3, 32'h3, 32'hFFFF_FFFF);
      check("R7", 32'h0, 1'b1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule